// File: doc/BRIEF.md
# Contact Card Power-Up Sequencer

This block brings a contact smart card from unpowered to ready. When the host pulls its active-low power command low, the sequencer waits a fixed settling interval, counted in oscillator cycles. It then switches on the card supply and starts counting a base period of `PERIOD` oscillator cycles. At fixed half-period offsets after supply-on it releases the data line and the two auxiliary lines, and later it drives card reset high, which ends the power-up.

Between those two points the host decides when the card clock starts. It does this by raising a clock-request pin. The request is honoured only once the data and auxiliary lines are released and before card reset rises. A request that comes too early, or never comes, is flagged as a timing violation, and card reset is still raised on schedule. If the clock-request pin is already high when the power command arrives, the sequencer refuses to start and flags a start error. Releasing the power command at any time returns every output to off.

Both host inputs pass through two synchroniser flip-flops before use. All delays below are counted in oscillator clock cycles.

Top module: `card_act_seq`

## Requirements
- R1: With `clk_req` low, `vcc_en` rises exactly `T1_CYC`+3 cycles after `pwr_cmd_n` falls. That is two synchroniser cycles, one cycle to enter the wait, then `T1_CYC` counted cycles.
- R2: `io_en`, `aux1_en` and `aux2_en` rise together exactly 5·`PERIOD`/2 cycles after `vcc_en` rises.
- R3: `card_rst` and `act_done` rise together exactly 11·`PERIOD`/2 cycles after `vcc_en` rises. Both then stay high while power is requested.
- R4: If `clk_req` rises while the lines are released and card reset is not yet high, `clk_en` rises exactly 3 cycles later. It then stays high until power is released, and `timing_err` stays low.
- R5: Outputs only turn on in sequence: `io_en` implies `vcc_en`, `clk_en` implies `io_en`, and `card_rst` implies `io_en`.
- R6: A synchronised high on `clk_req` after supply-on but before the lines are released sets `timing_err`. `card_rst` still rises on time.
- R7: If `clk_en` has not been applied by the time card reset rises, `timing_err` is set, `clk_en` stays low and `card_rst` still rises on time.
- R8: If `clk_req` is high when the power command is seen, `start_err` rises 3 cycles after `pwr_cmd_n` falls. In that case no supply, line, clock or reset output turns on.
- R9: Once `pwr_cmd_n` goes high, all outputs and flags are low exactly 3 cycles later, from any phase. This includes the settling wait, in which case nothing turns on afterwards.
- R10: After `rst_n` all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_cmd_n | input | 1 | Host power command, active low, asynchronous |
| clk_req | input | 1 | Host clock-request pin, asynchronous |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card data line enable |
| aux1_en | output | 1 | First auxiliary line enable |
| aux2_en | output | 1 | Second auxiliary line enable |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset level |
| act_done | output | 1 | Power-up complete |
| timing_err | output | 1 | Clock request outside its window |
| start_err | output | 1 | Clock request high at start |

## Verification
The assertions assume that the host holds `pwr_cmd_n` steady long enough for the synchronisers to settle. They also assume that `clk_req` changes no more than once per few cycles, so that the synchronised copies follow the pins. The stimulus changes either pin only on falling clock edges and keeps each level for many cycles. Random clock-request instants are drawn at least two cycles after the lines are released and ten cycles before reset. The directed early, missing and start-error cases sit well clear of the window edges, so no check lands on a boundary that the two-stage delay would blur.

// File: rtl/card_act_pkg.sv
package card_act_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RUN, ST_DONE, ST_FAULT
  } act_state_e;

  // offset of n half base periods, in oscillator cycles
  function automatic int unsigned half_periods(input int unsigned period, input int unsigned n);
    return (period * n) / 2;
  endfunction
endpackage

// File: rtl/card_act_sync.sv
module card_act_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      stg1 <= d;
      q    <= stg1;
    end
  end
endmodule

// File: rtl/card_act_core.sv
module card_act_core
  import card_act_pkg::*;
#(
  parameter int unsigned T1_CYC = 5325,
  parameter int unsigned PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic clk_req_s,
  output logic ev_fault,
  output logic ev_t1,
  output logic ev_t3,
  output logic ev_t5,
  output logic in_run
);
  localparam int unsigned IO_OFS  = half_periods(PERIOD, 5);
  localparam int unsigned RST_OFS = half_periods(PERIOD, 11);
  localparam int unsigned MAXC    = (T1_CYC > RST_OFS) ? T1_CYC : RST_OFS;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] T1_LAST  = CW'(T1_CYC - 1);
  localparam logic [CW-1:0] IO_LAST  = CW'(IO_OFS - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_OFS - 1);

  act_state_e    st;
  logic [CW-1:0] cnt;

  assign ev_t1    = (st == ST_WAIT) && (cnt == T1_LAST);
  assign ev_t3    = (st == ST_RUN)  && (cnt == IO_LAST);
  assign ev_t5    = (st == ST_RUN)  && (cnt == RST_LAST);
  assign ev_fault = (st == ST_IDLE) && pwr_req && clk_req_s;
  assign in_run   = (st == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (!pwr_req) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          st  <= clk_req_s ? ST_FAULT : ST_WAIT;
          cnt <= '0;
        end
        ST_WAIT: begin
          if (ev_t1) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (ev_t5) st <= ST_DONE;
          else       cnt <= cnt + 1'b1;
        end
        ST_DONE:  st <= ST_DONE;
        ST_FAULT: st <= ST_FAULT;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/card_act_drive.sv
module card_act_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic clk_req_s,
  input  logic in_run,
  input  logic ev_fault,
  input  logic ev_t1,
  input  logic ev_t3,
  input  logic ev_t5,
  output logic vcc_en,
  output logic lines_en,
  output logic clk_en,
  output logic card_rst,
  output logic act_done,
  output logic timing_err,
  output logic start_err
);
  logic clk_grant;
  assign clk_grant = in_run && lines_en && clk_req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_en <= 1'b0; lines_en <= 1'b0; clk_en <= 1'b0; card_rst <= 1'b0;
      act_done <= 1'b0; timing_err <= 1'b0; start_err <= 1'b0;
    end else if (!pwr_req) begin
      vcc_en <= 1'b0; lines_en <= 1'b0; clk_en <= 1'b0; card_rst <= 1'b0;
      act_done <= 1'b0; timing_err <= 1'b0; start_err <= 1'b0;
    end else begin
      if (ev_t1)     vcc_en    <= 1'b1;
      if (ev_t3)     lines_en  <= 1'b1;
      if (ev_fault)  start_err <= 1'b1;
      if (clk_grant) clk_en    <= 1'b1;
      if (ev_t5) begin
        card_rst <= 1'b1;
        act_done <= 1'b1;
        if (!clk_en && !clk_grant) timing_err <= 1'b1;
      end
      if (in_run && !lines_en && clk_req_s) timing_err <= 1'b1;
    end
  end
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq #(
  parameter int unsigned T1_CYC = 5325,
  parameter int unsigned PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_cmd_n,
  input  logic clk_req,
  output logic vcc_en,
  output logic io_en,
  output logic aux1_en,
  output logic aux2_en,
  output logic clk_en,
  output logic card_rst,
  output logic act_done,
  output logic timing_err,
  output logic start_err
);
  logic [1:0] raw_in, syn_in;
  logic pwr_req, clk_req_s;
  logic ev_fault, ev_t1, ev_t3, ev_t5, in_run, lines_en;

  assign raw_in = {pwr_cmd_n, clk_req};

  card_act_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign pwr_req   = ~syn_in[1];
  assign clk_req_s = syn_in[0];

  card_act_core #(.T1_CYC(T1_CYC), .PERIOD(PERIOD)) u_core (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .clk_req_s(clk_req_s),
    .ev_fault(ev_fault), .ev_t1(ev_t1), .ev_t3(ev_t3), .ev_t5(ev_t5), .in_run(in_run)
  );

  card_act_drive u_drive (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .clk_req_s(clk_req_s),
    .in_run(in_run), .ev_fault(ev_fault), .ev_t1(ev_t1), .ev_t3(ev_t3), .ev_t5(ev_t5),
    .vcc_en(vcc_en), .lines_en(lines_en), .clk_en(clk_en), .card_rst(card_rst),
    .act_done(act_done), .timing_err(timing_err), .start_err(start_err)
  );

  assign io_en   = lines_en;
  assign aux1_en = lines_en;
  assign aux2_en = lines_en;
endmodule

// File: rtl/card_act_checker.sv
module card_act_checker
  import card_act_pkg::*;
#(
  parameter int unsigned PERIOD = 64
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_req,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic card_rst,
  input logic act_done,
  input logic timing_err,
  input logic start_err
);
  localparam int unsigned IO_OFS  = half_periods(PERIOD, 5);
  localparam int unsigned RST_OFS = half_periods(PERIOD, 11);
  localparam int KW = $clog2(RST_OFS + 2) + 1;

  logic [KW-1:0] since_vcc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       since_vcc <= '0;
    else if (!vcc_en) since_vcc <= '0;
    else if (since_vcc != '1) since_vcc <= since_vcc + 1'b1;
  end

  a_r1_vcc_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(pwr_req));
  a_r2_lines_offset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_en) |-> since_vcc == KW'(IO_OFS));
  a_r3_rst_offset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> since_vcc == KW'(RST_OFS));
  a_r3_done_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_done) |-> card_rst);
  a_r5_io_order: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);
  a_r5_clk_order: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);
  a_r5_rst_order: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> io_en);
  a_r7_rst_has_clk_or_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> (clk_en || timing_err));
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> !vcc_en);
  a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_req) |=> (!vcc_en && !act_done && !timing_err && !start_err));
endmodule

bind card_act_seq card_act_checker #(.PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .vcc_en(vcc_en), .io_en(io_en),
  .clk_en(clk_en), .card_rst(card_rst), .act_done(act_done),
  .timing_err(timing_err), .start_err(start_err)
);

// File: tb/card_act_seq_bench.sv
module card_act_seq_bench;
  localparam int unsigned T1 = 50;
  localparam int unsigned PER = 64;

  function automatic int lines_delay(int p); return (p * 5) >> 1; endfunction
  function automatic int rst_delay(int p);   return (p * 11) >> 1; endfunction

  localparam int IO_D  = lines_delay(PER);
  localparam int RST_D = rst_delay(PER);

  logic clk = 1'b0, rst_n = 1'b0, pwr_cmd_n = 1'b1, clk_req = 1'b0;
  logic vcc_en, io_en, aux1_en, aux2_en, clk_en, card_rst, act_done, timing_err, start_err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  card_act_seq #(.T1_CYC(T1), .PERIOD(PER)) u_card_act_seq (
    .clk(clk), .rst_n(rst_n), .pwr_cmd_n(pwr_cmd_n), .clk_req(clk_req),
    .vcc_en(vcc_en), .io_en(io_en), .aux1_en(aux1_en), .aux2_en(aux2_en),
    .clk_en(clk_en), .card_rst(card_rst), .act_done(act_done),
    .timing_err(timing_err), .start_err(start_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic all_off();
    return !(vcc_en | io_en | aux1_en | aux2_en | clk_en | card_rst | act_done | timing_err | start_err);
  endfunction

  // mode 0: request at n=j, 1: short early pulse, 2: no request
  task automatic run_act(input int mode, input int j, input int hold);
    @(negedge clk); pwr_cmd_n = 1'b0; clk_req = 1'b0;
    repeat (T1 + 2) @(negedge clk);
    chk("R1 vcc before", vcc_en, 1'b0);
    @(negedge clk);
    chk("R1 vcc on", vcc_en, 1'b1);
    for (int n = 1; n <= RST_D + 4; n++) begin
      @(negedge clk);
      if (n == IO_D - 1) chk("R2 lines before", io_en, 1'b0);
      if (n == IO_D) chk("R2 lines on", io_en & aux1_en & aux2_en, 1'b1);
      if (n == RST_D - 1) chk("R3 rst before", card_rst | act_done, 1'b0);
      if (n == RST_D) begin
        chk("R3 rst and done on", card_rst & act_done, 1'b1);
        chk("R5 order", (!io_en || vcc_en) && (!clk_en || io_en) && (!card_rst || io_en), 1'b1);
      end
      if (mode == 0 && n == j + 2) chk("R4 clk before", clk_en, 1'b0);
      if (mode == 0 && n == j + 3) chk("R4 clk on", clk_en, 1'b1);
      if (mode != 2 && n == j) clk_req = 1'b1;
      if (mode == 1 && n == j + 6) clk_req = 1'b0;
    end
    if (mode == 0) begin
      chk("R4 no timing error", timing_err, 1'b0);
      chk("R4 clk held", clk_en, 1'b1);
    end else if (mode == 1) begin
      chk("R6 early flagged", timing_err, 1'b1);
      chk("R6 rst still raised", card_rst, 1'b1);
    end else begin
      chk("R7 late flagged", timing_err, 1'b1);
      chk("R7 clk stays off", clk_en, 1'b0);
      chk("R7 rst still raised", card_rst, 1'b1);
    end
    repeat (hold) @(negedge clk);
    chk("R3 done held", act_done, 1'b1);
    pwr_cmd_n = 1'b1; clk_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 still on before clear", vcc_en, 1'b1);
    @(negedge clk);
    chk("R9 all off", all_off(), 1'b1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset outputs off", all_off(), 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle after reset", all_off(), 1'b1);

    // directed corner cases
    run_act(0, IO_D + 2, 3);
    run_act(0, RST_D - 10, 7);
    run_act(1, IO_D - 40, 4);
    run_act(2, 0, 6);

    // start error: request pin already high
    @(negedge clk); clk_req = 1'b1;
    repeat (3) @(negedge clk);
    pwr_cmd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 no error yet", start_err, 1'b0);
    @(negedge clk);
    chk("R8 start error", start_err, 1'b1);
    repeat (T1 + RST_D + 10) @(negedge clk);
    chk("R8 stays quiet", vcc_en | io_en | clk_en | card_rst | act_done, 1'b0);
    pwr_cmd_n = 1'b1; clk_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 fault cleared", all_off(), 1'b1);

    // release during the settling wait
    @(negedge clk); pwr_cmd_n = 1'b0;
    repeat (T1 / 2) @(negedge clk);
    pwr_cmd_n = 1'b1;
    repeat (T1 + RST_D + 10) @(negedge clk);
    chk("R9 abort keeps all off", all_off(), 1'b1);

    // random request instants inside the window
    for (int t = 0; t < 12; t++) begin
      int jj = $urandom_range(RST_D - 10, IO_D + 2);
      int hh = $urandom_range(20, 1);
      run_act(0, jj, hh);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule